// File: doc/BRIEF.md
# Receiver Enable and Start-up Sequencer

This block governs the power states of a low-data-rate receiver's digital back end. It is clocked from the crystal-rate clock. A divider turns that clock into a base tick, and the mode input sets the division ratio. A two-pin baud-range code is decoded into a range number. The range number sets the extended tick, which is a fixed multiple of the base tick: slower baud ranges use a longer extended tick.

An enable input is synchronized and then drives a three-state machine: sleep, start-up and receive. While in sleep, nothing runs except the incoming clock. When enable rises, the block enters start-up. It stays there for a range-dependent number of base ticks so that downstream processing can settle, and then enters receive and raises a ready flag. A low on enable in any state sends the block back to sleep. Mode and range are captured only while the block sleeps, so moving those pins during operation changes nothing until the next wake-up.

Top module: `rxen_seq`

## Requirements
- R1: A synchronous active-high reset puts the block in sleep (state code 00) with base_tick_o, ext_tick_o, rx_ready_o and range_o all zero, effective at the first rising edge with reset high.
- R2: In start-up and receive, base_tick_o is a one-cycle pulse every 10 clocks when the captured mode is 0 and every 14 clocks when it is 1. The first pulse appears that many clocks after start-up is entered. No pulse appears in sleep.
- R3: The range pins br_i decode to the reported range_o as 00 to 0, 01 to 1, 10 to 2 and 11 to 3.
- R4: ext_tick_o pulses on every 8th, 4th, 2nd or 1st base tick for ranges 0, 1, 2 and 3, and only together with a base_tick_o pulse.
- R5: Enable passes through a two-flop synchronizer. The state leaves sleep on the third rising edge after enable_i goes high. From any other state, it returns to sleep on the third rising edge after enable_i goes low.
- R6: Start-up (state code 01) lasts 897, 513, 513 or 321 base ticks for ranges 0 to 3, which is that count times the division ratio in clocks. The block then enters receive (state code 10).
- R7: Leaving start-up through a low enable clears the start-up count, so the next wake-up waits the full start-up time again.
- R8: Receive is held for as long as enable stays high. rx_ready_o is high in exactly the cycles in which the state is receive.
- R9: Mode and range pins are sampled only in sleep. Changing them during start-up or receive affects neither range_o, nor the tick periods, nor the start-up length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal-rate clock |
| rst_i | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Asynchronous wake request, high to receive |
| mode_i | input | 1 | Divider select: 0 gives divide by 10, 1 gives divide by 14 |
| br_i | input | 2 | Baud-range code pins |
| base_tick_o | output | 1 | One-cycle base tick pulse |
| ext_tick_o | output | 1 | One-cycle extended tick pulse |
| range_o | output | 2 | Captured baud range |
| state_o | output | 2 | 00 sleep, 01 start-up, 10 receive |
| rx_ready_o | output | 1 | High while in receive |

## Verification
The bench counts the exact start-up length for every range under both divider ratios. A design with an off-by-one in the tick divider or the start-up counter would be wrong by 10 to 14 clocks or more, and the count would show it. It drops enable in the middle of start-up and then wakes the block again. A design that kept its partial count would enter receive too early. It moves mode and range pins during start-up. A design that sampled them live would change range_o, stretch or shorten start-up, or alter the extended tick period. It also checks that ticks stop completely in sleep and that the synchronizer latency is exactly three edges in both directions.

// File: rtl/rxen_pkg.sv
package rxen_pkg;

  typedef enum logic [1:0] {
    ST_SLEEP = 2'b00,
    ST_START = 2'b01,
    ST_RECV  = 2'b10
  } rx_state_e;

  // Range pin code to range number; code 11 maps to the fastest range.
  function automatic logic [1:0] decode_range(input logic [1:0] pins);
    logic [1:0] r;
    case (pins)
      2'b00:   r = 2'd0;
      2'b01:   r = 2'd1;
      2'b10:   r = 2'd2;
      default: r = 2'd3;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rxen_sync.sv
module rxen_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i) begin
        if (rst_i) chain[0] <= 1'b0;
        else       chain[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i) begin
        if (rst_i) chain[i] <= 1'b0;
        else       chain[i] <= chain[i-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/rxen_cfg_hold.sv
module rxen_cfg_hold
  import rxen_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       sleep_i,
  input  logic       mode_i,
  input  logic [1:0] br_i,
  output logic       mode_o,
  output logic [1:0] range_o
);

  // Capture the configuration pins only while asleep; hold them otherwise.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mode_o  <= 1'b0;
      range_o <= 2'd0;
    end else if (sleep_i) begin
      mode_o  <= mode_i;
      range_o <= decode_range(br_i);
    end
  end

endmodule

// File: rtl/rxen_tick_gen.sv
module rxen_tick_gen #(
  parameter int DIV_LO = 10,
  parameter int DIV_HI = 14,
  parameter int XMAX   = 8
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       run_i,
  input  logic       mode_i,
  input  logic [1:0] range_i,
  output logic       btick_o,
  output logic       base_tick_o,
  output logic       ext_tick_o
);

  localparam int DIV_MAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
  localparam int DW      = $clog2(DIV_MAX);
  localparam int XW      = (XMAX > 1) ? $clog2(XMAX) : 1;

  logic [DW-1:0] div_cnt;
  logic [DW-1:0] div_lim;
  logic [XW-1:0] x_cnt;
  logic [XW-1:0] x_lim;
  logic          x_hit;

  assign div_lim = mode_i ? DW'(DIV_HI - 1) : DW'(DIV_LO - 1);
  assign x_lim   = XW'((XMAX >> range_i) - 1);
  assign btick_o = run_i && (div_cnt == div_lim);
  assign x_hit   = btick_o && (x_cnt == x_lim);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      div_cnt     <= '0;
      x_cnt       <= '0;
      base_tick_o <= 1'b0;
      ext_tick_o  <= 1'b0;
    end else begin
      base_tick_o <= btick_o;
      ext_tick_o  <= x_hit;
      if (!run_i) begin
        div_cnt <= '0;
        x_cnt   <= '0;
      end else begin
        div_cnt <= btick_o ? '0 : div_cnt + 1'b1;
        if (btick_o) x_cnt <= x_hit ? '0 : x_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rxen_fsm.sv
module rxen_fsm
  import rxen_pkg::*;
#(
  parameter int SU0 = 897,
  parameter int SU1 = 513,
  parameter int SU2 = 513,
  parameter int SU3 = 321
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       en_i,
  input  logic       btick_i,
  input  logic [1:0] range_i,
  output rx_state_e  state_o,
  output logic       rx_ready_o
);

  localparam int SU_A   = (SU0 > SU1) ? SU0 : SU1;
  localparam int SU_B   = (SU2 > SU3) ? SU2 : SU3;
  localparam int SU_MAX = (SU_A > SU_B) ? SU_A : SU_B;
  localparam int SW     = $clog2(SU_MAX + 1);

  logic [SW-1:0] su_cnt;
  logic [SW-1:0] su_lim;
  logic          su_done;
  rx_state_e     nxt;

  always_comb begin
    case (range_i)
      2'd0:    su_lim = SW'(SU0 - 1);
      2'd1:    su_lim = SW'(SU1 - 1);
      2'd2:    su_lim = SW'(SU2 - 1);
      default: su_lim = SW'(SU3 - 1);
    endcase
  end

  assign su_done = btick_i && (su_cnt == su_lim);

  always_comb begin
    nxt = state_o;
    if (!en_i) begin
      nxt = ST_SLEEP;
    end else begin
      case (state_o)
        ST_SLEEP: nxt = ST_START;
        ST_START: if (su_done) nxt = ST_RECV;
        ST_RECV:  nxt = ST_RECV;
        default:  nxt = ST_SLEEP;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_o    <= ST_SLEEP;
      rx_ready_o <= 1'b0;
      su_cnt     <= '0;
    end else begin
      state_o    <= nxt;
      rx_ready_o <= (nxt == ST_RECV);
      if (state_o != ST_START || !en_i) su_cnt <= '0;
      else if (btick_i)                 su_cnt <= su_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/rxen_seq.sv
module rxen_seq
  import rxen_pkg::*;
#(
  parameter int DIV_LO      = 10,
  parameter int DIV_HI      = 14,
  parameter int XMAX        = 8,
  parameter int SU0         = 897,
  parameter int SU1         = 513,
  parameter int SU2         = 513,
  parameter int SU3         = 321,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       enable_i,
  input  logic       mode_i,
  input  logic [1:0] br_i,
  output logic       base_tick_o,
  output logic       ext_tick_o,
  output logic [1:0] range_o,
  output logic [1:0] state_o,
  output logic       rx_ready_o
);

  logic      en_sync;
  logic      cfg_mode;
  logic [1:0] cfg_range;
  logic      btick;
  logic      run;
  rx_state_e state;

  rxen_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (enable_i),
    .q_o   (en_sync)
  );

  rxen_cfg_hold cfg_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .sleep_i (state == ST_SLEEP),
    .mode_i  (mode_i),
    .br_i    (br_i),
    .mode_o  (cfg_mode),
    .range_o (cfg_range)
  );

  assign run = (state != ST_SLEEP) && en_sync;

  rxen_tick_gen #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI), .XMAX(XMAX)) tick_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .run_i       (run),
    .mode_i      (cfg_mode),
    .range_i     (cfg_range),
    .btick_o     (btick),
    .base_tick_o (base_tick_o),
    .ext_tick_o  (ext_tick_o)
  );

  rxen_fsm #(.SU0(SU0), .SU1(SU1), .SU2(SU2), .SU3(SU3)) fsm_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .en_i       (en_sync),
    .btick_i    (btick),
    .range_i    (cfg_range),
    .state_o    (state),
    .rx_ready_o (rx_ready_o)
  );

  assign state_o = state;
  assign range_o = cfg_range;

endmodule

// File: rtl/rxen_seq_chk.sv
module rxen_seq_chk #(
  parameter int DIV_LO = 10,
  parameter int DIV_HI = 14,
  parameter int SU0    = 897,
  parameter int SU1    = 513,
  parameter int SU2    = 513,
  parameter int SU3    = 321
) (
  input logic       clk_i,
  input logic       rst_i,
  input logic       en_s,
  input logic       cfg_mode,
  input logic       base_tick_o,
  input logic       ext_tick_o,
  input logic [1:0] range_o,
  input logic [1:0] state_o,
  input logic       rx_ready_o
);

  int st_len;
  int exp_len;

  always_comb begin
    case (range_o)
      2'd0:    exp_len = SU0;
      2'd1:    exp_len = SU1;
      2'd2:    exp_len = SU2;
      default: exp_len = SU3;
    endcase
    exp_len = exp_len * (cfg_mode ? DIV_HI : DIV_LO);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || state_o != 2'b01) st_len <= 0;
    else                           st_len <= st_len + 1;
  end

  a_r2_quiet_in_sleep: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_o == 2'b00) |-> !base_tick_o && !ext_tick_o);

  a_r4_ext_on_base: assert property (@(posedge clk_i) disable iff (rst_i)
    ext_tick_o |-> base_tick_o);

  a_r5_low_enable_sleeps: assert property (@(posedge clk_i) disable iff (rst_i)
    (!en_s && state_o != 2'b00) |=> (state_o == 2'b00));

  a_r6_startup_length: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(rx_ready_o) |-> (st_len == exp_len));

  a_r6_recv_via_startup: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_o == 2'b10) |-> ($past(state_o) != 2'b00));

  a_r8_ready_in_recv: assert property (@(posedge clk_i) disable iff (rst_i)
    rx_ready_o == (state_o == 2'b10));

  a_r9_cfg_held: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_o != 2'b00 && $past(state_o) != 2'b00) |-> ($stable(range_o) && $stable(cfg_mode)));

endmodule

bind rxen_seq rxen_seq_chk #(
  .DIV_LO(DIV_LO), .DIV_HI(DIV_HI),
  .SU0(SU0), .SU1(SU1), .SU2(SU2), .SU3(SU3)
) chk_i (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .en_s        (en_sync),
  .cfg_mode    (cfg_mode),
  .base_tick_o (base_tick_o),
  .ext_tick_o  (ext_tick_o),
  .range_o     (range_o),
  .state_o     (state_o),
  .rx_ready_o  (rx_ready_o)
);

// File: tb/rxen_seq_tb.sv
module rxen_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic       mode = 1'b0;
  logic [1:0] br = 2'b00;
  logic       base_tick, ext_tick, rx_ready;
  logic [1:0] range_q, state_q;

  int checks = 0;
  int fails  = 0;

  localparam int WATCHDOG = 150000;
  // {mode, br}
  localparam logic [2:0] VEC [0:5] = '{3'b000, 3'b100, 3'b001, 3'b110, 3'b011, 3'b111};

  always #2 clk = ~clk;

  rxen_seq dut_i (
    .clk_i       (clk),
    .rst_i       (rst),
    .enable_i    (enable),
    .mode_i      (mode),
    .br_i        (br),
    .base_tick_o (base_tick),
    .ext_tick_o  (ext_tick),
    .range_o     (range_q),
    .state_o     (state_q),
    .rx_ready_o  (rx_ready)
  );

  function automatic int e_div(input logic m);
    return m ? 14 : 10;
  endfunction

  function automatic int e_su(input int r);
    case (r)
      0: return 897;
      1: return 513;
      2: return 513;
      default: return 321;
    endcase
  endfunction

  function automatic int e_n(input int r);
    return 8 >> r;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic steps_until_state(input logic [1:0] s, output int k);
    k = 0;
    do begin step(); k++; end while (state_q != s && k < 100000);
  endtask

  // Called on the first sample in start-up; returns the start-up length and first tick index.
  task automatic measure_start(output int len, output int first_tick);
    int idx = 0;
    first_tick = -1;
    while (state_q == 2'b01) begin
      if (base_tick && first_tick < 0) first_tick = idx;
      step();
      idx++;
    end
    len = idx;
  endtask

  task automatic measure_period(input bit use_ext, output int p);
    int g = 0;
    while (!(use_ext ? ext_tick : base_tick) && g < 1000) begin step(); g++; end
    p = 0;
    do begin step(); p++; end while (!(use_ext ? ext_tick : base_tick) && p < 1000);
  endtask

  task automatic drop_enable();
    int k;
    enable = 1'b0;
    steps_until_state(2'b00, k);
    check(k == 3, "R5 sleep latency", k, 3);
    check(rx_ready == 1'b0, "R8 ready low in sleep", int'(rx_ready), 0);
  endtask

  task automatic run_vector(input logic m, input logic [1:0] b);
    int k, len, ft, p;
    int r = int'(b);
    int d = e_div(m);
    mode = m; br = b; enable = 1'b1;
    steps_until_state(2'b01, k);
    check(k == 3, "R5 wake latency", k, 3);
    check(int'(range_q) == r, "R3 range decode", int'(range_q), r);
    measure_start(len, ft);
    check(len == e_su(r) * d, "R6 startup length", len, e_su(r) * d);
    check(ft == d, "R2 first base tick", ft, d);
    check(state_q == 2'b10 && rx_ready, "R8 receive ready", int'(state_q), 2);
    measure_period(1'b0, p);
    check(p == d, "R2 base period", p, d);
    measure_period(1'b1, p);
    check(p == d * e_n(r), "R4 ext period", p, d * e_n(r));
    drop_enable();
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected 0 cycles left", WATCHDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int k, len, ft, p, bad, ticks, idx;
    // R1: reset state
    repeat (3) step();
    check(state_q == 2'b00, "R1 reset state", int'(state_q), 0);
    check(!base_tick && !ext_tick, "R1 reset ticks", int'(base_tick), 0);
    check(!rx_ready && range_q == 2'd0, "R1 reset ready/range", int'(range_q), 0);
    rst = 1'b0;
    step();

    // Table-driven sweep of mode and range
    for (int i = 0; i < 6; i++) run_vector(VEC[i][2], VEC[i][1:0]);

    // R9: pins moved during start-up are ignored
    mode = 1'b0; br = 2'b11; enable = 1'b1;
    steps_until_state(2'b01, k);
    idx = 0;
    while (state_q == 2'b01) begin
      if (idx == 100) begin mode = 1'b1; br = 2'b00; end
      step();
      idx++;
    end
    check(idx == 3210, "R9 startup length held", idx, 3210);
    check(range_q == 2'd3, "R9 range held", int'(range_q), 3);
    measure_period(1'b1, p);
    check(p == 10, "R9 ext period held", p, 10);
    // R8: receive persists while enable high
    bad = 0;
    for (int j = 0; j < 300; j++) begin
      step();
      if (state_q != 2'b10 || !rx_ready) bad++;
    end
    check(bad == 0, "R8 receive held", bad, 0);
    drop_enable();

    // R7: abort start-up, then full wait again
    mode = 1'b1; br = 2'b01; enable = 1'b1;
    steps_until_state(2'b01, k);
    repeat (500) step();
    enable = 1'b0;
    steps_until_state(2'b00, k);
    check(k == 3, "R5 abort latency", k, 3);
    ticks = 0;
    for (int j = 0; j < 40; j++) begin
      step();
      if (base_tick || ext_tick) ticks++;
    end
    check(ticks == 0, "R2 no ticks in sleep", ticks, 0);
    enable = 1'b1;
    steps_until_state(2'b01, k);
    measure_start(len, ft);
    check(len == 7182, "R7 full restart length", len, 7182);

    // R1: reset while receiving
    rst = 1'b1;
    step();
    check(state_q == 2'b00 && !rx_ready, "R1 reset from receive", int'(state_q), 0);
    enable = 1'b0;
    repeat (3) step();
    rst = 1'b0;
    repeat (5) step();
    check(state_q == 2'b00, "R1 stays asleep", int'(state_q), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule